// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Fill Warnings

This block is a first-in first-out buffer whose producer and consumer run on unrelated clocks. Words of 18 bits go in on the write clock and come out, one per read, on the read clock through a registered output. Both enables and the reset are active low. The depth is a power of two and is set by a parameter. Five active-low status outputs report the fill level. Empty and the low-fill warning belong to the read side. Full, half-full and the high-fill warning belong to the write side.

Two 14-bit threshold registers set how close to empty and how close to full the two warnings fire. Software loads them through the normal data input while the load control is held low. Successive loads alternate between the low-fill threshold and the high-fill threshold. The same alternating order is used to read the thresholds back on the data output. An output enable forces the data output to zero without disturbing the output register.

Pointers cross between the clock domains as Gray codes through a synchroniser chain. Each side computes its flags from its own pointer and its synchronised copy of the other side's pointer.

Top module: `pflag_fifo`

## Requirements
- R1: While rstN is low, emptyN is low, fullN, halfN and highWarnN (for a depth above the default mark) are high, dOut is zero, and nothing is stored or fetched. Reset returns both thresholds to DEF_MARK and both selection sequences to the low-fill threshold.
- R2: When wrEnN is low, loadN is high and the FIFO is not full, dIn is stored on the rising edge of wrClk. When rdEnN is low, loadN is high and the FIFO is not empty, the oldest stored word is placed on dOut at the rising edge of rdClk. Words leave in the order they were stored.
- R3: A write attempted while fullN is low stores nothing and does not change the contents.
- R4: A read attempted while emptyN is low consumes nothing, and dOut keeps the last word read.
- R5: emptyN is low exactly when the read side sees zero stored words, and it changes only on rdClk edges. fullN is low exactly when the write side sees DEPTH stored words, and it changes only on wrClk edges.
- R6: With loadN low and wrEnN low, dIn[13:0] is loaded on each wrClk edge. The first such edge loads the low-fill threshold, the next loads the high-fill threshold, and the sequence keeps alternating. Raising loadN between loads does not reset the position in the sequence.
- R7: With loadN low and wrEnN high, neither threshold nor the load sequence changes.
- R8: With loadN low and rdEnN low, each rdClk edge places a threshold on dOut, with dOut[13:0] holding the value and dOut[17:14] zero. The read side keeps its own alternating order, starting with the low-fill threshold.
- R9: lowWarnN is low when the stored count is at or below the low-fill threshold. It is updated on rdClk edges.
- R10: highWarnN is low when the free space (DEPTH minus the count) is at or below the high-fill threshold. It is updated on wrClk edges.
- R11: halfN is low when the stored count is above DEPTH/2. It is updated on wrClk edges.
- R12: While outEnN is high, dOut is all zero. When outEnN goes low again, the held output word reappears.
- R13: While loadN is low, no data word is stored or consumed, whatever the enables are doing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEnN | input | 1 | Write enable, active low |
| rdEnN | input | 1 | Read enable, active low |
| loadN | input | 1 | Threshold access select, active low |
| outEnN | input | 1 | Output enable, active low |
| dIn | input | DATA_W | Write data, or a threshold value in bits 13:0 |
| dOut | output | DATA_W | Read data or threshold readback, zero while disabled |
| emptyN | output | 1 | Low when empty (read clock) |
| fullN | output | 1 | Low when full (write clock) |
| halfN | output | 1 | Low when more than half full (write clock) |
| lowWarnN | output | 1 | Low when count is at or below the low-fill threshold (read clock) |
| highWarnN | output | 1 | Low when free space is at or below the high-fill threshold (write clock) |

## Verification
A write and a read can fall in the same interval, one on each clock. In that case each side's flags follow its own clock. A flag can therefore stay stale while only the other clock runs. The bench provokes this by stopping one clock during a transfer. It fills the buffer, stops wrClk and reads one word: fullN must stay low until wrClk resumes. It drains the buffer, stops rdClk and writes one word: emptyN must stay low until rdClk resumes. After each resumption the bench compares every flag and the output order against its own count model.

// File: rtl/pflag_fifo_pkg.sv
package pflag_fifo_pkg;

  // Strobes raised by the write-side control for the datapath
  typedef struct packed {
    logic store;     // push dIn into the array
    logic loadLow;   // capture low-fill threshold
    logic loadHigh;  // capture high-fill threshold
  } wrStrobe_t;

  // Strobes raised by the read-side control for the datapath
  typedef struct packed {
    logic fetch;     // move oldest word into the output register
    logic showLow;   // put low-fill threshold into the output register
    logic showHigh;  // put high-fill threshold into the output register
  } rdStrobe_t;

endpackage

// File: rtl/pflag_fifo_sync.sv
module pflag_fifo_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] grayIn,
  output logic [W-1:0] binOut
);

  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= grayIn;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  // Gray to binary: each bit is the parity of all bits above and including it
  for (genvar b = 0; b < W; b++) begin : g_bit
    assign binOut[b] = ^chain[STAGES-1][W-1:b];
  end

endmodule

// File: rtl/pflag_fifo_ctrl.sv
module pflag_fifo_ctrl
  import pflag_fifo_pkg::*;
#(
  parameter int AW          = 8,
  parameter int MARK_W      = 14,
  parameter int DEF_MARK    = 127,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              wrEnN,
  input  logic              rdEnN,
  input  logic              loadN,
  input  logic [MARK_W-1:0] lowMark,
  input  logic [MARK_W-1:0] highMark,
  output logic [AW:0]       wrPtr,
  output logic [AW:0]       rdPtr,
  output wrStrobe_t         wrStb,
  output rdStrobe_t         rdStb,
  output logic              emptyN,
  output logic              fullN,
  output logic              halfN,
  output logic              lowWarnN,
  output logic              highWarnN
);

  localparam int            PW       = AW + 1;
  localparam int            CW       = PW + MARK_W;
  localparam logic [PW-1:0] DEPTH_C  = PW'(1) << AW;
  localparam logic [PW-1:0] HALF_C   = PW'(1) << (AW - 1);
  localparam bit            HIGH_RST = ((1 << AW) <= DEF_MARK);

  // ---------------- write domain ----------------
  logic [PW-1:0] wrBin, wrGray, wrNext, rdSeen, fillW, spaceW;
  logic          fullQ, halfQ, highQ, wrSel;

  assign wrStb.store    = !wrEnN && loadN && !fullQ;
  assign wrStb.loadLow  = !wrEnN && !loadN && !wrSel;
  assign wrStb.loadHigh = !wrEnN && !loadN && wrSel;

  assign wrNext = wrBin + PW'(wrStb.store);
  assign fillW  = wrNext - rdSeen;
  assign spaceW = DEPTH_C - fillW;

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrBin  <= '0;
      wrGray <= '0;
      fullQ  <= 1'b0;
      halfQ  <= 1'b0;
      highQ  <= HIGH_RST;
      wrSel  <= 1'b0;
    end else begin
      wrBin  <= wrNext;
      wrGray <= wrNext ^ (wrNext >> 1);
      fullQ  <= (fillW == DEPTH_C);
      halfQ  <= (fillW > HALF_C);
      highQ  <= (CW'(spaceW) <= CW'(highMark));
      if (wrStb.loadLow || wrStb.loadHigh) wrSel <= !wrSel;
    end
  end

  pflag_fifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_rdToWr (
    .clk    (wrClk),
    .rstN   (rstN),
    .grayIn (rdGray),
    .binOut (rdSeen)
  );

  // ---------------- read domain ----------------
  logic [PW-1:0] rdBin, rdGray, rdNext, wrSeen, fillR;
  logic          emptyQ, lowQ, rdSel;

  assign rdStb.fetch    = !rdEnN && loadN && !emptyQ;
  assign rdStb.showLow  = !rdEnN && !loadN && !rdSel;
  assign rdStb.showHigh = !rdEnN && !loadN && rdSel;

  assign rdNext = rdBin + PW'(rdStb.fetch);
  assign fillR  = wrSeen - rdNext;

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdBin  <= '0;
      rdGray <= '0;
      emptyQ <= 1'b1;
      lowQ   <= 1'b1;
      rdSel  <= 1'b0;
    end else begin
      rdBin  <= rdNext;
      rdGray <= rdNext ^ (rdNext >> 1);
      emptyQ <= (fillR == '0);
      lowQ   <= (CW'(fillR) <= CW'(lowMark));
      if (rdStb.showLow || rdStb.showHigh) rdSel <= !rdSel;
    end
  end

  pflag_fifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_wrToRd (
    .clk    (rdClk),
    .rstN   (rstN),
    .grayIn (wrGray),
    .binOut (wrSeen)
  );

  assign wrPtr     = wrBin;
  assign rdPtr     = rdBin;
  assign emptyN    = !emptyQ;
  assign fullN     = !fullQ;
  assign halfN     = !halfQ;
  assign lowWarnN  = !lowQ;
  assign highWarnN = !highQ;

endmodule

// File: rtl/pflag_fifo_datapath.sv
module pflag_fifo_datapath
  import pflag_fifo_pkg::*;
#(
  parameter int DATA_W   = 18,
  parameter int AW       = 8,
  parameter int MARK_W   = 14,
  parameter int DEF_MARK = 127
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  wrStrobe_t         wrStb,
  input  rdStrobe_t         rdStb,
  input  logic [AW-1:0]     wrAddr,
  input  logic [AW-1:0]     rdAddr,
  input  logic [DATA_W-1:0] dIn,
  input  logic              outEnN,
  output logic [DATA_W-1:0] dOut,
  output logic [MARK_W-1:0] lowMark,
  output logic [MARK_W-1:0] highMark
);

  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] cells [DEPTH];
  logic [DATA_W-1:0] outReg;

  always_ff @(posedge wrClk) begin
    if (wrStb.store) cells[wrAddr] <= dIn;
  end

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      lowMark  <= MARK_W'(DEF_MARK);
      highMark <= MARK_W'(DEF_MARK);
    end else begin
      if (wrStb.loadLow)  lowMark  <= dIn[MARK_W-1:0];
      if (wrStb.loadHigh) highMark <= dIn[MARK_W-1:0];
    end
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      outReg <= '0;
    end else if (rdStb.fetch) begin
      outReg <= cells[rdAddr];
    end else if (rdStb.showLow) begin
      outReg <= DATA_W'(lowMark);
    end else if (rdStb.showHigh) begin
      outReg <= DATA_W'(highMark);
    end
  end

  assign dOut = outEnN ? '0 : outReg;

endmodule

// File: rtl/pflag_fifo.sv
module pflag_fifo
  import pflag_fifo_pkg::*;
#(
  parameter int DATA_W      = 18,
  parameter int ADDR_W      = 8,
  parameter int MARK_W      = 14,
  parameter int DEF_MARK    = 127,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              wrEnN,
  input  logic              rdEnN,
  input  logic              loadN,
  input  logic              outEnN,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] dOut,
  output logic              emptyN,
  output logic              fullN,
  output logic              halfN,
  output logic              lowWarnN,
  output logic              highWarnN
);

  wrStrobe_t         wrStb;
  rdStrobe_t         rdStb;
  logic [ADDR_W:0]   wrPtr;
  logic [ADDR_W:0]   rdPtr;
  logic [MARK_W-1:0] lowMark;
  logic [MARK_W-1:0] highMark;

  pflag_fifo_ctrl #(
    .AW          (ADDR_W),
    .MARK_W      (MARK_W),
    .DEF_MARK    (DEF_MARK),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_ctrl (
    .wrClk     (wrClk),
    .rdClk     (rdClk),
    .rstN      (rstN),
    .wrEnN     (wrEnN),
    .rdEnN     (rdEnN),
    .loadN     (loadN),
    .lowMark   (lowMark),
    .highMark  (highMark),
    .wrPtr     (wrPtr),
    .rdPtr     (rdPtr),
    .wrStb     (wrStb),
    .rdStb     (rdStb),
    .emptyN    (emptyN),
    .fullN     (fullN),
    .halfN     (halfN),
    .lowWarnN  (lowWarnN),
    .highWarnN (highWarnN)
  );

  pflag_fifo_datapath #(
    .DATA_W   (DATA_W),
    .AW       (ADDR_W),
    .MARK_W   (MARK_W),
    .DEF_MARK (DEF_MARK)
  ) u_datapath (
    .wrClk    (wrClk),
    .rdClk    (rdClk),
    .rstN     (rstN),
    .wrStb    (wrStb),
    .rdStb    (rdStb),
    .wrAddr   (wrPtr[ADDR_W-1:0]),
    .rdAddr   (rdPtr[ADDR_W-1:0]),
    .dIn      (dIn),
    .outEnN   (outEnN),
    .dOut     (dOut),
    .lowMark  (lowMark),
    .highMark (highMark)
  );

endmodule

// File: rtl/pflag_fifo_chk.sv
module pflag_fifo_chk #(
  parameter int AW = 8
) (
  input logic        wrClk,
  input logic        rdClk,
  input logic        rstN,
  input logic        loadN,
  input logic [AW:0] wrPtr,
  input logic [AW:0] rdPtr,
  input logic        emptyN,
  input logic        fullN,
  input logic        halfN,
  input logic        lowWarnN,
  input logic        highWarnN
);

  // R3: a full buffer never advances the write pointer
  a_r3_no_overflow: assert property (@(posedge wrClk) disable iff (!rstN)
    !fullN |=> $stable(wrPtr));

  // R4: an empty buffer never advances the read pointer
  a_r4_no_underflow: assert property (@(posedge rdClk) disable iff (!rstN)
    !emptyN |=> $stable(rdPtr));

  // R13: threshold access blocks data movement on both sides
  a_r13_load_holds_wr: assert property (@(posedge wrClk) disable iff (!rstN)
    !loadN |=> $stable(wrPtr));
  a_r13_load_holds_rd: assert property (@(posedge rdClk) disable iff (!rstN)
    !loadN |=> $stable(rdPtr));

  // R2: pointers move by at most one word per edge
  a_r2_wr_step: assert property (@(posedge wrClk) disable iff (!rstN)
    1'b1 |=> (wrPtr == $past(wrPtr)) || (wrPtr == $past(wrPtr) + (AW+1)'(1)));
  a_r2_rd_step: assert property (@(posedge rdClk) disable iff (!rstN)
    1'b1 |=> (rdPtr == $past(rdPtr)) || (rdPtr == $past(rdPtr) + (AW+1)'(1)));

  // R11: full implies more than half full
  a_r11_half_when_full: assert property (@(posedge wrClk) disable iff (!rstN)
    !fullN |-> !halfN);

  // R10: full implies the high-fill warning
  a_r10_high_when_full: assert property (@(posedge wrClk) disable iff (!rstN)
    !fullN |-> !highWarnN);

  // R9: empty implies the low-fill warning
  a_r9_low_when_empty: assert property (@(posedge rdClk) disable iff (!rstN)
    !emptyN |-> !lowWarnN);

endmodule

bind pflag_fifo pflag_fifo_chk #(.AW(ADDR_W)) u_chk (
  .wrClk     (wrClk),
  .rdClk     (rdClk),
  .rstN      (rstN),
  .loadN     (loadN),
  .wrPtr     (wrPtr),
  .rdPtr     (rdPtr),
  .emptyN    (emptyN),
  .fullN     (fullN),
  .halfN     (halfN),
  .lowWarnN  (lowWarnN),
  .highWarnN (highWarnN)
);

// File: tb/pflag_fifo_bench.sv
module pflag_fifo_bench;

  localparam int WR_PERIOD = 10;
  localparam int RD_PERIOD = 14;
  localparam int AW        = 4;
  localparam int DEPTH     = 1 << AW;
  localparam int DEF       = 3;

  // op codes: 0 write, 1 read, 2 load threshold, 3 show threshold, 4 idle load
  localparam logic [20:0] VEC [16] = '{
    {3'd0, 18'h00011}, {3'd0, 18'h3ABCD}, {3'd1, 18'h0}, {3'd0, 18'h12345},
    {3'd1, 18'h0},     {3'd1, 18'h0},     {3'd1, 18'h0}, {3'd2, 18'h00005},
    {3'd2, 18'h00002}, {3'd4, 18'h3FFFF}, {3'd2, 18'h3C009}, {3'd3, 18'h0},
    {3'd3, 18'h0},     {3'd0, 18'h2FFFF}, {3'd3, 18'h0}, {3'd1, 18'h0}
  };

  logic        wrClk = 1'b0, rdClk = 1'b0;
  logic        wrRun = 1'b1, rdRun = 1'b1;
  logic        rstN  = 1'b0;
  logic        wrEnN = 1'b1, rdEnN = 1'b1, loadN = 1'b1, outEnN = 1'b0;
  logic [17:0] dIn   = '0;
  logic [17:0] dOut;
  logic        emptyN, fullN, halfN, lowWarnN, highWarnN;

  int checks = 0;
  int errors = 0;

  logic [17:0] mq [$];
  logic [13:0] lowM = 14'(DEF), highM = 14'(DEF);
  logic        wrSelM = 1'b0, rdSelM = 1'b0;
  logic [17:0] lastQ = '0;

  pflag_fifo #(.ADDR_W(AW), .DEF_MARK(DEF)) u_pflag_fifo (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .wrEnN(wrEnN), .rdEnN(rdEnN),
    .loadN(loadN), .outEnN(outEnN), .dIn(dIn), .dOut(dOut), .emptyN(emptyN),
    .fullN(fullN), .halfN(halfN), .lowWarnN(lowWarnN), .highWarnN(highWarnN)
  );

  initial forever begin
    #(WR_PERIOD/2);
    if (wrRun || wrClk) wrClk = ~wrClk;
  end
  initial forever begin
    #(RD_PERIOD/2);
    if (rdRun || rdClk) rdClk = ~rdClk;
  end

  task automatic check(input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic checkFlags(input string outTag);
    int n;
    n = mq.size();
    check("R5",  "emptyN",    32'(emptyN),    32'(n != 0));
    check("R5",  "fullN",     32'(fullN),     32'(n != DEPTH));
    check("R11", "halfN",     32'(halfN),     32'(!(n > DEPTH/2)));
    check("R9",  "lowWarnN",  32'(lowWarnN),  32'(!(n <= int'(lowM))));
    check("R10", "highWarnN", 32'(highWarnN), 32'(!((DEPTH - n) <= int'(highM))));
    check(outTag, "dOut", 32'(dOut), 32'(lastQ));
  endtask

  task automatic settleWr();
    repeat (6) @(negedge wrClk);
  endtask
  task automatic settleRd();
    repeat (6) @(negedge rdClk);
  endtask

  task automatic doWrite(input logic [17:0] d);
    @(negedge wrClk); wrEnN = 1'b0; dIn = d;
    @(negedge wrClk); wrEnN = 1'b1;
    if (mq.size() < DEPTH) mq.push_back(d);
  endtask

  task automatic doRead();
    @(negedge rdClk); rdEnN = 1'b0;
    @(negedge rdClk); rdEnN = 1'b1;
    if (mq.size() > 0) lastQ = mq.pop_front();
  endtask

  task automatic doLoad(input logic [17:0] d);
    @(negedge wrClk); loadN = 1'b0; wrEnN = 1'b0; dIn = d;
    @(negedge wrClk); loadN = 1'b1; wrEnN = 1'b1;
    if (!wrSelM) lowM = d[13:0]; else highM = d[13:0];
    wrSelM = !wrSelM;
  endtask

  task automatic doIdleLoad(input logic [17:0] d);
    @(negedge wrClk); loadN = 1'b0; dIn = d;
    @(negedge wrClk); loadN = 1'b1;
  endtask

  task automatic doShow();
    @(negedge rdClk); loadN = 1'b0; rdEnN = 1'b0;
    @(negedge rdClk); loadN = 1'b1; rdEnN = 1'b1;
    lastQ = rdSelM ? 18'(highM) : 18'(lowM);
    rdSelM = !rdSelM;
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(WR_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual running expected finished");
    finishRun();
  end

  initial begin
    // R1: state held in reset
    repeat (3) @(negedge wrClk);
    check("R1", "emptyN", 32'(emptyN), 0);
    check("R1", "fullN", 32'(fullN), 1);
    check("R1", "halfN", 32'(halfN), 1);
    check("R1", "highWarnN", 32'(highWarnN), 1);
    check("R1", "dOut", 32'(dOut), 0);
    @(negedge wrClk); rstN = 1'b1;
    settleRd();

    // table walk: data order, empty hold, threshold load and readback order
    for (int i = 0; i < 16; i++) begin
      logic [2:0]  op;
      logic [17:0] d;
      string       tag;
      op = VEC[i][20:18];
      d  = VEC[i][17:0];
      case (op)
        3'd0: begin tag = "R2"; doWrite(d); end
        3'd1: begin tag = (mq.size() == 0) ? "R4" : "R2"; doRead(); end
        3'd2: begin tag = "R6"; doLoad(d); end
        3'd3: begin tag = "R8"; doShow(); end
        default: begin tag = "R7"; doIdleLoad(d); end
      endcase
      settleWr(); settleRd();
      checkFlags(tag);
    end

    // R3 and R11/R10: fill to the limit, then push once more
    for (int k = 0; k < DEPTH; k++) begin
      doWrite(18'(k * 4099 + 7));
      settleWr(); settleRd();
      checkFlags("R2");
    end
    doWrite(18'h15555);
    settleWr(); settleRd();
    checkFlags("R3");

    // R5: full flag waits for the write clock
    wrRun = 1'b0;
    repeat (3) @(negedge rdClk);
    doRead();
    settleRd();
    check("R5", "fullN with wrClk stopped", 32'(fullN), 0);
    wrRun = 1'b1;
    settleWr(); settleRd();
    checkFlags("R2");

    // drain in order; the refused word must never appear (R3)
    while (mq.size() > 0) begin
      doRead();
      settleWr(); settleRd();
      checkFlags("R3");
    end

    // R5: empty flag waits for the read clock
    rdRun = 1'b0;
    repeat (3) @(negedge wrClk);
    doWrite(18'h0ABCD);
    settleWr();
    check("R5", "emptyN with rdClk stopped", 32'(emptyN), 0);
    rdRun = 1'b1;
    settleWr(); settleRd();
    checkFlags("R2");
    doRead();
    settleWr(); settleRd();
    checkFlags("R2");

    // R12: output gate
    outEnN = 1'b1;
    @(negedge rdClk);
    check("R12", "dOut gated", 32'(dOut), 0);
    outEnN = 1'b0;
    @(negedge rdClk);
    check("R12", "dOut restored", 32'(dOut), 32'(lastQ));

    // R1: reset mid-run restores defaults and the selection order
    doWrite(18'h01234);
    settleWr(); settleRd();
    @(negedge wrClk); rstN = 1'b0;
    #1;
    check("R1", "emptyN", 32'(emptyN), 0);
    check("R1", "dOut", 32'(dOut), 0);
    mq.delete();
    lowM = 14'(DEF); highM = 14'(DEF); wrSelM = 1'b0; rdSelM = 1'b0; lastQ = '0;
    repeat (2) @(negedge wrClk);
    rstN = 1'b1;
    settleWr(); settleRd();
    checkFlags("R1");
    doLoad(18'h00006);
    doShow();
    settleRd();
    check("R1", "readback after reset", 32'(dOut), 32'(6));
    doShow();
    settleRd();
    check("R1", "default high mark", 32'(dOut), 32'(DEF));

    finishRun();
  end

endmodule